// File: doc/BRIEF.md
# Programmable Carrier Wave Generator

This block is a small down-counting timer that turns two programmed phase lengths into a square carrier. A counter loads one of two reload values, counts down on a selectable source tick, and on underflow flips the carrier phase and loads the value that belongs to the new phase. A 4-bit control word starts and stops the count, picks a full-rate or half-rate source tick, gates the carrier onto its output, and can stretch every high phase by one extra tick.

Software writes the control word and the two reload values through simple write strobes. The block reports each underflow, marks each rising carrier edge with a one-cycle pulse for a downstream timer, and raises a configuration error when stretching is active with a high reload value of zero. After reset the counter holds zero in the low phase, so the first source tick after starting ends that phase and begins a high phase.

Top module: `carrier_gen`

## Requirements
- R1: After reset the control word is 0, and `carrier_o`, `underflow_o`, `carrier_tick_o` and `cfg_err_o` are all 0.
- R2: Control bit 0 runs the counter, bit 1 selects the source tick, bit 2 enables the carrier output and bit 3 enables high-phase stretching. With bit 1 at 0 a source tick occurs on every clock, so a high phase lasts (high reload + 1) clocks and a low phase (low reload + 1) clocks.
- R3: With control bit 1 at 1 a source tick occurs every second clock, doubling every phase length in clocks.
- R4: While control bit 0 is 0 the counter, the phase and the carrier hold their values and no underflow occurs; counting resumes from the held value.
- R5: With bits 2 and 3 both set, every high phase lasts one source tick longer (high reload + 2 ticks); low phases are unchanged.
- R6: With bit 2 clear, bit 3 has no effect: the phases keep lengths of reload + 1 ticks.
- R7: With bit 2 clear, `carrier_o` stays 0 while the counter keeps running and reporting underflows.
- R8: `cfg_err_o` is 1 exactly when bits 2 and 3 are set and the high reload value is 0.
- R9: A reload write while running does not alter the phase in progress; the new value is used from the next load of that phase onward.
- R10: A control write that changes bit 1 while the counter runs keeps the previous source selection; the change is accepted only while bit 0 is 0.
- R11: `carrier_tick_o` pulses for one clock in the same cycle that `carrier_o` rises, and at no other time.
- R12: `underflow_o` pulses for one clock at each phase change, in the cycle the carrier output changes while bit 2 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 4 | Control word: bit0 run, bit1 half-rate, bit2 carrier enable, bit3 stretch |
| hi_we | input | 1 | High-phase reload write strobe |
| lo_we | input | 1 | Low-phase reload write strobe |
| reload_wdata | input | 8 | Reload value written by either strobe |
| carrier_o | output | 1 | Carrier output |
| underflow_o | output | 1 | One-cycle pulse on each counter underflow |
| carrier_tick_o | output | 1 | One-cycle pulse on each carrier rising edge |
| cfg_err_o | output | 1 | Stretching active with a zero high reload |

## Verification
The hardest situation to reach from the ports is a reload write landing inside a running phase, since the phase in progress must keep its old length while the next one picks up the new value. The bench waits until it observes the carrier rise, writes a new high value in that very cycle, and then measures the current high phase, the following low phase and the next high phase in clocks. The locked source selection is reached the same way: a control write with the half-rate bit flipped is issued mid-run and the phase lengths are measured before and after a stop.

// File: rtl/cg_pkg.sv
package cg_pkg;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    // Bit 3 down to bit 0 of the control word.
    typedef struct packed {
        logic hi_stretch;
        logic wave_en;
        logic half_rate;
        logic run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // New control word from a write; the rate bit is locked while running.
    function automatic ctrl_t merge_ctrl(input ctrl_t cur, input logic [CTRL_W-1:0] wd);
        ctrl_t nxt;
        nxt = ctrl_t'(wd);
        if (cur.run) begin
            nxt.half_rate = cur.half_rate;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/cg_ctrl_regs.sv
module cg_ctrl_regs
    import cg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              hi_we,
    input  logic              lo_we,
    input  logic [W-1:0]      reload_wdata,
    output ctrl_t             ctrl_o,
    output logic [W-1:0]      hi_o,
    output logic [W-1:0]      lo_o
);

    ctrl_t        ctrl_q;
    logic [W-1:0] hi_q;
    logic [W-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            hi_q   <= '0;
            lo_q   <= '0;
        end else begin
            if (ctrl_we) begin
                ctrl_q <= merge_ctrl(ctrl_q, ctrl_wdata);
            end
            if (hi_we) begin
                hi_q <= reload_wdata;
            end
            if (lo_we) begin
                lo_q <= reload_wdata;
            end
        end
    end

    assign ctrl_o = ctrl_q;
    assign hi_o   = hi_q;
    assign lo_o   = lo_q;

    // R10: source selection cannot move while the counter runs
    a_r10_rate_locked: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.run |=> $stable(ctrl_q.half_rate));

endmodule

// File: rtl/cg_prescaler.sv
module cg_prescaler (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic half_i,
    output logic tick_o
);

    logic div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= 1'b0;
        end else if (run_i) begin
            div_q <= ~div_q;
        end
    end

    assign tick_o = run_i & (~half_i | div_q);

    // R3: at half rate two ticks never come back to back
    a_r3_half_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick_o && half_i) |=> !tick_o);

    // R4: no tick while stopped
    a_r4_no_tick_stopped: assert property (@(posedge clk) disable iff (rst)
        !run_i |-> !tick_o);

endmodule

// File: rtl/cg_phase_counter.sv
module cg_phase_counter
    import cg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_i,
    input  logic         tick_i,
    input  logic         wave_en_i,
    input  logic         stretch_i,
    input  logic [W-1:0] hi_i,
    input  logic [W-1:0] lo_i,
    output phase_e       phase_o,
    output logic         underflow_o,
    output logic         rise_o
);

    localparam int CW = W + 1;

    logic [CW-1:0] cnt_q;
    phase_e        ph_q;
    logic          uf_q;
    logic          rise_q;
    logic [CW-1:0] hi_load;
    logic [CW-1:0] lo_load;

    assign hi_load = {1'b0, hi_i} + {{W{1'b0}}, stretch_i};
    assign lo_load = {1'b0, lo_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            ph_q   <= PH_LOW;
            uf_q   <= 1'b0;
            rise_q <= 1'b0;
        end else begin
            uf_q   <= 1'b0;
            rise_q <= 1'b0;
            if (tick_i) begin
                if (cnt_q == '0) begin
                    uf_q <= 1'b1;
                    if (ph_q == PH_LOW) begin
                        ph_q   <= PH_HIGH;
                        cnt_q  <= hi_load;
                        rise_q <= wave_en_i;
                    end else begin
                        ph_q  <= PH_LOW;
                        cnt_q <= lo_load;
                    end
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign phase_o     = ph_q;
    assign underflow_o = uf_q;
    assign rise_o      = rise_q;

    // R4: a stopped counter keeps its value and phase
    a_r4_hold_count: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> ($stable(cnt_q) && $stable(ph_q)));

    // R12: every underflow pulse comes with a phase change
    a_r12_flip_on_uf: assert property (@(posedge clk) disable iff (rst)
        uf_q |-> (ph_q != $past(ph_q)));

    // R12: the phase never changes without an underflow pulse
    a_r12_uf_on_flip: assert property (@(posedge clk) disable iff (rst)
        (ph_q != $past(ph_q)) |-> uf_q);

    // R11: rise marker only on entry into the high phase
    a_r11_rise_entry: assert property (@(posedge clk) disable iff (rst)
        rise_q |-> (ph_q == PH_HIGH && $past(ph_q) == PH_LOW));

endmodule

// File: rtl/carrier_gen.sv
module carrier_gen
    import cg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ctrl_we,
    input  logic [3:0]   ctrl_wdata,
    input  logic         hi_we,
    input  logic         lo_we,
    input  logic [W-1:0] reload_wdata,
    output logic         carrier_o,
    output logic         underflow_o,
    output logic         carrier_tick_o,
    output logic         cfg_err_o
);

    ctrl_t        ctrl;
    logic [W-1:0] hi_val;
    logic [W-1:0] lo_val;
    logic         tick;
    logic         stretch_eff;
    phase_e       phase;
    logic         rise;

    cg_ctrl_regs #(.W(W)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .ctrl_we      (ctrl_we),
        .ctrl_wdata   (ctrl_wdata),
        .hi_we        (hi_we),
        .lo_we        (lo_we),
        .reload_wdata (reload_wdata),
        .ctrl_o       (ctrl),
        .hi_o         (hi_val),
        .lo_o         (lo_val)
    );

    cg_prescaler u_pre (
        .clk    (clk),
        .rst    (rst),
        .run_i  (ctrl.run),
        .half_i (ctrl.half_rate),
        .tick_o (tick)
    );

    // Stretching only counts when the carrier is enabled.
    assign stretch_eff = ctrl.hi_stretch & ctrl.wave_en;

    cg_phase_counter #(.W(W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .run_i       (ctrl.run),
        .tick_i      (tick),
        .wave_en_i   (ctrl.wave_en),
        .stretch_i   (stretch_eff),
        .hi_i        (hi_val),
        .lo_i        (lo_val),
        .phase_o     (phase),
        .underflow_o (underflow_o),
        .rise_o      (rise)
    );

    assign carrier_o      = ctrl.wave_en & (phase == PH_HIGH);
    assign carrier_tick_o = rise;
    assign cfg_err_o      = stretch_eff & (hi_val == '0);

    // R7: carrier held low while generation is disabled
    a_r7_low_when_off: assert property (@(posedge clk) disable iff (rst)
        !ctrl.wave_en |-> !carrier_o);

    // R1: outputs quiet in the first cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!carrier_o && !underflow_o && !carrier_tick_o));

endmodule

// File: tb/carrier_gen_test.sv
`timescale 1ns/1ps
module carrier_gen_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       ctrl_we;
    logic [3:0] ctrl_wdata;
    logic       hi_we;
    logic       lo_we;
    logic [7:0] reload_wdata;
    logic       carrier_o;
    logic       underflow_o;
    logic       carrier_tick_o;
    logic       cfg_err_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    carrier_gen uut (
        .clk            (clk),
        .rst            (rst),
        .ctrl_we        (ctrl_we),
        .ctrl_wdata     (ctrl_wdata),
        .hi_we          (hi_we),
        .lo_we          (lo_we),
        .reload_wdata   (reload_wdata),
        .carrier_o      (carrier_o),
        .underflow_o    (underflow_o),
        .carrier_tick_o (carrier_tick_o),
        .cfg_err_o      (cfg_err_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<50000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [3:0] v);
        ctrl_we = 1'b1; ctrl_wdata = v; step(); ctrl_we = 1'b0;
    endtask

    task automatic wr_hi(input logic [7:0] v);
        hi_we = 1'b1; reload_wdata = v; step(); hi_we = 1'b0;
    endtask

    task automatic wr_lo(input logic [7:0] v);
        lo_we = 1'b1; reload_wdata = v; step(); lo_we = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; ctrl_we = 0; hi_we = 0; lo_we = 0;
        ctrl_wdata = 0; reload_wdata = 0;
        step(); step();
        rst = 1'b0;
        step();
    endtask

    // Wait for a sampled 0->1 carrier transition; sample stands on the first high cycle.
    task automatic wait_rise();
        logic prev;
        prev = carrier_o;
        for (int i = 0; i < 2000; i++) begin
            step();
            if (carrier_o && !prev) return;
            prev = carrier_o;
        end
    endtask

    // Count cycles at the current level, starting with the current sample.
    task automatic count_level(input logic lvl, output int n);
        n = 0;
        while (carrier_o == lvl && n < 2000) begin
            n++;
            step();
        end
    endtask

    task automatic measure(output int hl, output int ll);
        wait_rise();
        count_level(1'b1, hl);
        count_level(1'b0, ll);
    endtask

    // Cycles from one underflow sample to the next.
    task automatic uf_gap(output int n);
        n = 0;
        while (!underflow_o && n < 2000) step();
        step();
        n = 1;
        while (!underflow_o && n < 2000) begin
            n++;
            step();
        end
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 carrier", carrier_o, 0);
        check("R1 underflow", underflow_o, 0);
        check("R1 tick", carrier_tick_o, 0);
        check("R1 err", cfg_err_o, 0);
    endtask

    task automatic t_full_rate();
        int h, l;
        do_reset();
        wr_hi(8'd3); wr_lo(8'd5);
        wr_ctrl(4'b0101);
        measure(h, l);
        check("R2 high len", h, 4);
        check("R2 low len", l, 6);
    endtask

    task automatic t_half_rate();
        int h, l;
        do_reset();
        wr_hi(8'd3); wr_lo(8'd5);
        wr_ctrl(4'b0111);
        measure(h, l);
        check("R3 high len", h, 8);
        check("R3 low len", l, 12);
    endtask

    task automatic t_stop_hold();
        int h, l, ufs, chg;
        logic c0;
        do_reset();
        wr_hi(8'd9); wr_lo(8'd9);
        wr_ctrl(4'b0101);
        wait_rise();
        step(); step();            // three high cycles seen incl. rise sample
        wr_ctrl(4'b0100);          // stop: run clears at this edge
        c0 = carrier_o; ufs = 0; chg = 0;
        for (int i = 0; i < 20; i++) begin
            if (underflow_o) ufs++;
            if (carrier_o != c0) chg++;
            step();
        end
        check("R4 held level", c0, 1);
        check("R4 no change", chg, 0);
        check("R4 no underflow", ufs, 0);
        wr_ctrl(4'b0101);
        count_level(1'b1, h);
        count_level(1'b0, l);
        // 10-cycle high phase: 3 before stop, 1 stop-write cycle counts at the run edge
        check("R4 resumed remainder", h, 1 + 10 - 4);
        check("R4 low after resume", l, 10);
    endtask

    task automatic t_stretch();
        int h, l;
        do_reset();
        wr_hi(8'd3); wr_lo(8'd5);
        wr_ctrl(4'b1101);
        measure(h, l);
        check("R5 stretched high", h, 5);
        check("R5 low unchanged", l, 6);
    endtask

    task automatic t_stretch_ignored();
        int g1, g2, hs;
        do_reset();
        wr_hi(8'd3); wr_lo(8'd5);
        wr_ctrl(4'b1001);
        uf_gap(g1);
        uf_gap(g2);
        check("R6 phase pair sum", g1 + g2, 10);
        hs = 0;
        for (int i = 0; i < 40; i++) begin
            if (carrier_o) hs++;
            step();
        end
        check("R7 carrier low while off", hs, 0);
        check("R6 no err while off", cfg_err_o, 0);
    endtask

    task automatic t_err();
        do_reset();
        wr_hi(8'd0);
        wr_ctrl(4'b1100);
        check("R8 err hi zero", cfg_err_o, 1);
        wr_hi(8'd1);
        check("R8 err hi one", cfg_err_o, 0);
        wr_hi(8'd0);
        wr_ctrl(4'b1000);
        check("R8 err wave off", cfg_err_o, 0);
        wr_ctrl(4'b0100);
        check("R8 err stretch off", cfg_err_o, 0);
    endtask

    task automatic t_reload_mid();
        int h1, l1, h2, l2;
        do_reset();
        wr_hi(8'd3); wr_lo(8'd5);
        wr_ctrl(4'b0101);
        wait_rise();
        hi_we = 1'b1; reload_wdata = 8'd7;
        h1 = 1; step(); hi_we = 1'b0;
        while (carrier_o && h1 < 2000) begin h1++; step(); end
        count_level(1'b0, l1);
        count_level(1'b1, h2);
        count_level(1'b0, l2);
        check("R9 current high keeps old", h1, 4);
        check("R9 low", l1, 6);
        check("R9 next high new", h2, 8);
    endtask

    task automatic t_rate_lock();
        int h, l;
        do_reset();
        wr_hi(8'd3); wr_lo(8'd5);
        wr_ctrl(4'b0101);
        wr_ctrl(4'b0111);          // rate change while running
        measure(h, l);
        check("R10 locked high", h, 4);
        check("R10 locked low", l, 6);
        wr_ctrl(4'b0100);
        wr_ctrl(4'b0110);          // accepted while stopped
        wr_ctrl(4'b0111);
        measure(h, l);
        check("R10 accepted high", h, 8);
    endtask

    task automatic t_pulses();
        int bad_tick, bad_uf, rises;
        logic prev;
        do_reset();
        wr_hi(8'd0); wr_lo(8'd2);
        wr_ctrl(4'b0101);
        prev = carrier_o; bad_tick = 0; bad_uf = 0; rises = 0;
        for (int i = 0; i < 60; i++) begin
            if (carrier_tick_o != (carrier_o && !prev)) bad_tick++;
            if (underflow_o != (carrier_o != prev)) bad_uf++;
            if (carrier_o && !prev) rises++;
            prev = carrier_o;
            step();
        end
        check("R11 tick on rise only", bad_tick, 0);
        check("R12 underflow on each change", bad_uf, 0);
        check("R11 rises seen", rises > 10, 1);
    endtask

    initial begin
        rst = 1'b1; ctrl_we = 0; hi_we = 0; lo_we = 0;
        ctrl_wdata = 0; reload_wdata = 0;
        t_reset();
        t_full_rate();
        t_half_rate();
        t_stop_hold();
        t_stretch();
        t_stretch_ignored();
        t_err();
        t_reload_mid();
        t_rate_lock();
        t_pulses();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule